// File: doc/BRIEF.md
# Secondary Processor Control and Mailbox Interrupt Block

This block sits between a primary processor and a secondary processor that share memory. Through a 16-bit register port, the primary processor can hold the secondary in reset and stop or start its clock. It also sets a relocation value. That value is added to the upper byte of every address the secondary issues, so the secondary's code can run from any 16 MiB window of shared memory.

Both processors can interrupt each other. Writing a doorbell location on one side sets pending bits on the other side. Each side has its own enable and pending registers, and each side has one interrupt line. Pending bits are cleared by writing ones to them. The secondary has its own register port, which reaches its enable and pending registers and its doorbell. Any write arriving on that port is dropped while the secondary is held in reset or its clock is stopped.

The usual start-up sequence is as follows. Put the secondary in reset and stop its clock. Clear all enables and pending bits. Load the code into memory. Then release the reset and write the relocation value in a single write. Finally, start the clock.

Top module: `cpu_pair_ctrl`

## Requirements
- R1: After reset, the primary control register reads 0x0080. The secondary is held in reset and its clock enable is 0. The relocation value, all enables and all pending bits are 0, and both interrupt lines are low.
- R2: A primary write to offset 0 sets the reset hold from bit 7 (1 = held) and the 7-bit relocation from bits 6:0. Both outputs change together in the cycle after the write. Reading offset 0 returns these 8 bits, with bits 15:8 as 0.
- R3: The relocated secondary address equals the input address with bits 31:24 replaced by (bits 31:24 + relocation) mod 256. Bits 23:0 pass through unchanged.
- R4: Bit 0 of a primary write to offset 1 drives the secondary clock enable (1 = run). Reading offset 1 returns that bit in bit 0.
- R5: A primary write to offset 6 ORs its data into the secondary pending register. A secondary write to its offset 2 ORs its data into the primary pending register. Both doorbell offsets read as 0.
- R6: Pending bits clear on a write of 1 and are kept on a write of 0. The primary pending register is written at primary offset 3. The secondary pending register is written at primary offset 5 or secondary offset 1. Writing 0xFFFF clears all bits.
- R7: Each interrupt line is high exactly when its pending register and its enable register share a set bit. An enable of 0 masks every source. Enables are written at primary offset 2 (primary side), primary offset 4 (secondary side) and secondary offset 0 (secondary side).
- R8: When a clear and a doorbell set reach the same pending bit in the same cycle, the bit ends up set.
- R9: While the secondary is held in reset or its clock enable is 0, every write on the secondary port is ignored. This includes doorbell, enable and pending writes.
- R10: Unmapped offsets read as 0 on both ports: primary offset 7 and secondary offsets 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p_sel | input | 1 | Primary port access strobe |
| p_wr | input | 1 | Primary access is a write |
| p_addr | input | 3 | Primary register offset |
| p_wdata | input | 16 | Primary write data |
| p_rdata | output | 16 | Primary read data (combinational, 0 when not selected) |
| s_sel | input | 1 | Secondary port access strobe |
| s_wr | input | 1 | Secondary access is a write |
| s_addr | input | 3 | Secondary register offset |
| s_wdata | input | 16 | Secondary write data |
| s_rdata | output | 16 | Secondary read data (combinational, 0 when not selected) |
| s_mem_addr_i | input | 32 | Address issued by the secondary processor |
| s_mem_addr_o | output | 32 | Relocated address sent to shared memory |
| sec_hold_rst | output | 1 | Holds the secondary processor in reset when 1 |
| sec_clk_en | output | 1 | Secondary processor clock enable |
| sec_reloc | output | 7 | Current relocation value |
| pri_irq | output | 1 | Interrupt to the primary processor |
| sec_irq | output | 1 | Interrupt to the secondary processor |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 7-bit relocation field and a 32-bit address with an 8-bit upper field. With these sizes, a relocation of 0x7F added to an upper byte of 0x90 wraps past 256. The top pending bit (bit 15) and the full 0xFFFF clear are also covered. Same-cycle collisions between a clear from one port and a doorbell from the other are driven directly. The ignore rule is checked twice, once in each of the two inactive states: held in reset, and clock stopped.

// File: rtl/cpu_pair_pkg.sv
// Package: register offsets shared by the control block and its bench.
// Assumes 3-bit word offsets on both register ports.
package cpu_pair_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        PA_CTRL     = 3'd0,
        PA_RUN      = 3'd1,
        PA_PRI_IEN  = 3'd2,
        PA_PRI_PEND = 3'd3,
        PA_SEC_IEN  = 3'd4,
        PA_SEC_PEND = 3'd5,
        PA_DOORBELL = 3'd6,
        PA_UNUSED   = 3'd7
    } pri_reg_e;

    typedef enum logic [ADDR_W-1:0] {
        SA_IEN      = 3'd0,
        SA_PEND     = 3'd1,
        SA_DOORBELL = 3'd2
    } sec_reg_e;
endpackage

// File: rtl/sec_ctrl_regs.sv
// Module: secondary processor reset/relocation and clock-run registers.
// Assumes write strobes are already decoded; the hold bit sits just above
// the relocation field so both update from a single write.
module sec_ctrl_regs #(
    parameter int unsigned REL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [REL_W:0]   ctrl_wd,
    input  logic             run_we,
    input  logic             run_wd,
    output logic             hold_o,
    output logic [REL_W-1:0] reloc_o,
    output logic             run_o
);
    // Hold bit and relocation field load together from one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o  <= 1'b1;
            reloc_o <= '0;
        end else if (ctrl_we) begin
            hold_o  <= ctrl_wd[REL_W];
            reloc_o <= ctrl_wd[REL_W-1:0];
        end
    end

    // Clock-run bit for the secondary processor.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_o <= 1'b0;
        else if (run_we) run_o <= run_wd;
    end

    // R2: hold output moves only after a control write.
    a_r2_hold_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_o) |-> $past(ctrl_we));

    // R4: run output moves only after a run write.
    a_r4_run_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_o) |-> $past(run_we));
endmodule

// File: rtl/mbox_side.sv
// Module: one side's interrupt state: enable register, write-1-to-clear
// pending register with doorbell set, and the masked interrupt line.
// Assumes two writers (port a has priority for the enable) and that a
// set wins over a clear on the same bit in the same cycle.
module mbox_side #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ien_we_a,
    input  logic [DW-1:0] ien_wd_a,
    input  logic          ien_we_b,
    input  logic [DW-1:0] ien_wd_b,
    input  logic [DW-1:0] clr_a,
    input  logic [DW-1:0] clr_b,
    input  logic [DW-1:0] set_i,
    output logic [DW-1:0] ien_o,
    output logic [DW-1:0] pend_o,
    output logic          irq_o
);
    // Enable register; port a wins when both ports write together.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_o <= '0;
        else if (ien_we_a) ien_o <= ien_wd_a;
        else if (ien_we_b) ien_o <= ien_wd_b;
    end

    // Pending register: apply both clears, then OR in new doorbell bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_a & ~clr_b) | set_i;
    end

    // Interrupt line is any enabled pending bit.
    always_comb irq_o = |(pend_o & ien_o);

    // R5: no pending bit appears without a doorbell set.
    a_r5_no_spurious_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~$past(pend_o) & ~$past(set_i)) == '0));

    // R8: every bit set by a doorbell is present next cycle.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R7: the line rises only after a doorbell or an enable write.
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|set_i) || ien_we_a || ien_we_b));
endmodule

// File: rtl/addr_reloc.sv
// Module: adds the relocation value to the upper address field of every
// secondary access; lower bits pass through. Purely combinational.
module addr_reloc #(
    parameter int unsigned MEM_AW = 32,
    parameter int unsigned HI_W   = 8,
    parameter int unsigned REL_W  = 7
) (
    input  logic [MEM_AW-1:0] addr_i,
    input  logic [REL_W-1:0]  reloc_i,
    output logic [MEM_AW-1:0] addr_o
);
    localparam int unsigned LO_W = MEM_AW - HI_W;

    logic [HI_W-1:0] hi_sum;

    // Upper field plus zero-extended relocation, wrapping modulo 2^HI_W.
    always_comb begin
        hi_sum = addr_i[MEM_AW-1:LO_W] + HI_W'(reloc_i);
        addr_o = {hi_sum, addr_i[LO_W-1:0]};
    end
endmodule

// File: rtl/cpu_pair_ctrl.sv
// Module: top of the dual-processor control block. Decodes the primary and
// secondary register ports, gates secondary writes while that processor is
// inactive, and muxes read data. Assumes single-cycle register accesses.
module cpu_pair_ctrl
    import cpu_pair_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned REL_W  = 7,
    parameter int unsigned MEM_AW = 32,
    parameter int unsigned HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_sel,
    input  logic              p_wr,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DW-1:0]     p_wdata,
    output logic [DW-1:0]     p_rdata,
    input  logic              s_sel,
    input  logic              s_wr,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DW-1:0]     s_wdata,
    output logic [DW-1:0]     s_rdata,
    input  logic [MEM_AW-1:0] s_mem_addr_i,
    output logic [MEM_AW-1:0] s_mem_addr_o,
    output logic              sec_hold_rst,
    output logic              sec_clk_en,
    output logic [REL_W-1:0]  sec_reloc,
    output logic              pri_irq,
    output logic              sec_irq
);
    localparam int unsigned CTRL_W = REL_W + 1;

    logic          p_we, s_we, sec_active;
    logic [DW-1:0] pri_ien, pri_pend, sec_ien, sec_pend;
    logic [DW-1:0] p_clr_pri, p_clr_sec, s_clr_sec, p_bell, s_bell;

    // Write qualification: secondary writes only while it runs.
    always_comb begin
        sec_active = !sec_hold_rst && sec_clk_en;
        p_we       = p_sel && p_wr;
        s_we       = s_sel && s_wr && sec_active;
    end

    // Clear and doorbell vectors decoded from the two ports.
    always_comb begin
        p_clr_pri = (p_we && p_addr == PA_PRI_PEND) ? p_wdata : '0;
        p_clr_sec = (p_we && p_addr == PA_SEC_PEND) ? p_wdata : '0;
        s_clr_sec = (s_we && s_addr == SA_PEND)     ? s_wdata : '0;
        p_bell    = (p_we && p_addr == PA_DOORBELL) ? p_wdata : '0;
        s_bell    = (s_we && s_addr == SA_DOORBELL) ? s_wdata : '0;
    end

    sec_ctrl_regs #(.REL_W(REL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (p_we && p_addr == PA_CTRL),
        .ctrl_wd (p_wdata[REL_W:0]),
        .run_we  (p_we && p_addr == PA_RUN),
        .run_wd  (p_wdata[0]),
        .hold_o  (sec_hold_rst),
        .reloc_o (sec_reloc),
        .run_o   (sec_clk_en)
    );

    mbox_side #(.DW(DW)) u_pri_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien_we_a (p_we && p_addr == PA_PRI_IEN),
        .ien_wd_a (p_wdata),
        .ien_we_b (1'b0),
        .ien_wd_b ('0),
        .clr_a    (p_clr_pri),
        .clr_b    ('0),
        .set_i    (s_bell),
        .ien_o    (pri_ien),
        .pend_o   (pri_pend),
        .irq_o    (pri_irq)
    );

    mbox_side #(.DW(DW)) u_sec_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien_we_a (p_we && p_addr == PA_SEC_IEN),
        .ien_wd_a (p_wdata),
        .ien_we_b (s_we && s_addr == SA_IEN),
        .ien_wd_b (s_wdata),
        .clr_a    (p_clr_sec),
        .clr_b    (s_clr_sec),
        .set_i    (p_bell),
        .ien_o    (sec_ien),
        .pend_o   (sec_pend),
        .irq_o    (sec_irq)
    );

    addr_reloc #(.MEM_AW(MEM_AW), .HI_W(HI_W), .REL_W(REL_W)) u_reloc (
        .addr_i  (s_mem_addr_i),
        .reloc_i (sec_reloc),
        .addr_o  (s_mem_addr_o)
    );

    // Primary read mux; doorbell and unmapped offsets return zero.
    always_comb begin
        p_rdata = '0;
        if (p_sel) begin
            case (p_addr)
                PA_CTRL:     p_rdata = DW'({sec_hold_rst, sec_reloc});
                PA_RUN:      p_rdata = DW'(sec_clk_en);
                PA_PRI_IEN:  p_rdata = pri_ien;
                PA_PRI_PEND: p_rdata = pri_pend;
                PA_SEC_IEN:  p_rdata = sec_ien;
                PA_SEC_PEND: p_rdata = sec_pend;
                default:     p_rdata = '0;
            endcase
        end
    end

    // Secondary read mux; reads are allowed even while inactive.
    always_comb begin
        s_rdata = '0;
        if (s_sel) begin
            case (s_addr)
                SA_IEN:  s_rdata = sec_ien;
                SA_PEND: s_rdata = sec_pend;
                default: s_rdata = '0;
            endcase
        end
    end

    // R9: a secondary write while inactive adds no primary pending bit.
    a_r9_inactive_no_bell: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel && s_wr && !(CTRL_W > 0 && !sec_hold_rst && sec_clk_en))
        |=> ((pri_pend & ~$past(pri_pend)) == '0));

    // R9: while inactive, the secondary enable moves only by primary write.
    a_r9_inactive_ien_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_hold_rst || !sec_clk_en) && !(p_we && p_addr == PA_SEC_IEN)
        |=> $stable(sec_ien));
endmodule

// File: tb/cpu_pair_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module cpu_pair_ctrl_tb;
    import cpu_pair_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_sel = 1'b0, p_wr = 1'b0;
    logic [2:0]  p_addr = '0;
    logic [15:0] p_wdata = '0;
    logic [15:0] p_rdata;
    logic        s_sel = 1'b0, s_wr = 1'b0;
    logic [2:0]  s_addr = '0;
    logic [15:0] s_wdata = '0;
    logic [15:0] s_rdata;
    logic [31:0] s_mem_addr_i = '0;
    logic [31:0] s_mem_addr_o;
    logic        sec_hold_rst, sec_clk_en, pri_irq, sec_irq;
    logic [6:0]  sec_reloc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_pair_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_mem_addr_i(s_mem_addr_i), .s_mem_addr_o(s_mem_addr_o),
        .sec_hold_rst(sec_hold_rst), .sec_clk_en(sec_clk_en), .sec_reloc(sec_reloc),
        .pri_irq(pri_irq), .sec_irq(sec_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pwr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        p_sel = 1'b1; p_wr = 1'b1; p_addr = a; p_wdata = d;
        @(negedge clk);
        p_sel = 1'b0; p_wr = 1'b0;
    endtask

    task automatic swr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_sel = 1'b0; s_wr = 1'b0;
    endtask

    task automatic prd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        p_sel = 1'b1; p_wr = 1'b0; p_addr = a;
        #1 d = p_rdata;
        p_sel = 1'b0;
    endtask

    task automatic srd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b0; s_addr = a;
        #1 d = s_rdata;
        s_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 hold", sec_hold_rst, 1);
        chk("R1 clk_en", sec_clk_en, 0);
        chk("R1 reloc", sec_reloc, 0);
        chk("R1 irqs", {pri_irq, sec_irq}, 0);
        prd(PA_CTRL, d);     chk("R1 ctrl read", d, 16'h0080);
        prd(PA_PRI_PEND, d); chk("R1 pri pend", d, 0);
        prd(PA_SEC_IEN, d);  chk("R1 sec ien", d, 0);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        pwr(PA_CTRL, 16'h0035);
        chk("R2 hold released", sec_hold_rst, 0);
        chk("R2 reloc", sec_reloc, 7'h35);
        prd(PA_CTRL, d); chk("R2 readback", d, 16'h0035);
        pwr(PA_CTRL, 16'hFFFF);
        chk("R2 hold set", sec_hold_rst, 1);
        chk("R2 reloc max", sec_reloc, 7'h7F);
        prd(PA_CTRL, d); chk("R2 upper bits zero", d, 16'h00FF);
    endtask

    task automatic t_reloc();
        s_mem_addr_i = 32'h9012_3456;
        #1 chk("R3 wrap", s_mem_addr_o, 32'h0F12_3456);
        pwr(PA_CTRL, 16'h0083);
        s_mem_addr_i = 32'h0000_1000;
        #1 chk("R3 offset 3", s_mem_addr_o, 32'h0300_1000);
    endtask

    task automatic t_run();
        logic [15:0] d;
        pwr(PA_RUN, 16'h0001);
        chk("R4 run on", sec_clk_en, 1);
        prd(PA_RUN, d); chk("R4 readback", d, 16'h0001);
        pwr(PA_RUN, 16'hFFFE);
        chk("R4 run off", sec_clk_en, 0);
    endtask

    task automatic t_ignore();
        logic [15:0] d;
        // held in reset, clock running
        pwr(PA_CTRL, 16'h0083); pwr(PA_RUN, 16'h0001);
        swr(SA_DOORBELL, 16'h0001);
        swr(SA_IEN, 16'hFFFF);
        prd(PA_PRI_PEND, d); chk("R9 held: bell ignored", d, 0);
        prd(PA_SEC_IEN, d);  chk("R9 held: ien ignored", d, 0);
        // released, clock stopped
        pwr(PA_CTRL, 16'h0003); pwr(PA_RUN, 16'h0000);
        pwr(PA_DOORBELL, 16'h0010);
        swr(SA_DOORBELL, 16'h0002);
        swr(SA_PEND, 16'hFFFF);
        prd(PA_PRI_PEND, d); chk("R9 paused: bell ignored", d, 0);
        prd(PA_SEC_PEND, d); chk("R9 paused: clear ignored", d, 16'h0010);
        chk("R9 pri irq low", pri_irq, 0);
        pwr(PA_SEC_PEND, 16'hFFFF);
    endtask

    task automatic t_mailbox();
        logic [15:0] d;
        pwr(PA_RUN, 16'h0001);
        swr(SA_DOORBELL, 16'h0005);
        prd(PA_PRI_PEND, d); chk("R5 sec->pri bell", d, 16'h0005);
        chk("R7 masked by zero enable", pri_irq, 0);
        pwr(PA_PRI_IEN, 16'h0004);
        chk("R7 enabled irq", pri_irq, 1);
        pwr(PA_DOORBELL, 16'h8000);
        srd(SA_PEND, d); chk("R5 pri->sec bell", d, 16'h8000);
        chk("R7 sec masked", sec_irq, 0);
        swr(SA_IEN, 16'h8000);
        chk("R7 sec enabled", sec_irq, 1);
        srd(SA_DOORBELL, d); chk("R5 doorbell reads zero", d, 0);
        prd(PA_DOORBELL, d); chk("R5 pri doorbell reads zero", d, 0);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        pwr(PA_PRI_PEND, 16'h0001);
        prd(PA_PRI_PEND, d); chk("R6 partial clear", d, 16'h0004);
        chk("R6 irq still up", pri_irq, 1);
        pwr(PA_PRI_PEND, 16'hFFFF);
        prd(PA_PRI_PEND, d); chk("R6 full clear", d, 0);
        chk("R6 irq dropped", pri_irq, 0);
        swr(SA_PEND, 16'hFFFF);
        srd(SA_PEND, d); chk("R6 sec clear", d, 0);
        chk("R6 sec irq dropped", sec_irq, 0);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        swr(SA_DOORBELL, 16'h0003);
        @(negedge clk);
        p_sel = 1'b1; p_wr = 1'b1; p_addr = PA_PRI_PEND; p_wdata = 16'h0003;
        s_sel = 1'b1; s_wr = 1'b1; s_addr = SA_DOORBELL; s_wdata = 16'h0001;
        @(negedge clk);
        p_sel = 1'b0; p_wr = 1'b0; s_sel = 1'b0; s_wr = 1'b0;
        prd(PA_PRI_PEND, d); chk("R8 set beats clear", d, 16'h0001);
    endtask

    task automatic t_map();
        logic [15:0] d;
        prd(PA_UNUSED, d); chk("R10 pri unmapped", d, 0);
        srd(3'd5, d);      chk("R10 sec unmapped", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_reloc();
        t_run();
        t_ignore();
        t_mailbox();
        t_w1c();
        t_collide();
        t_map();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule